// File: doc/BRIEF.md
# Multiplexed LCD Segment Waveform Sequencer

This block produces the digital drive pattern for a multiplexed segment display with 32 frontplane pins and 4 backplane pins. It does not drive voltages itself. For every pin it outputs a 2-bit level index, which an external analog stage turns into one of up to four bias voltages. It also outputs a drive-enable that the pad ring uses for tri-state control. The segment states sit in a 128-bit display store. Each frontplane owns one 4-bit word in it, and bit b of that word belongs to backplane b. The store is reached over a simple single-cycle register bus, and it works as ordinary storage even while the driver is off.

A prescaler outside the block supplies a one-cycle `tick` per drive phase. A frame has one time slot per active backplane, and each slot has two phases of opposite polarity, so every pin averages to zero over a frame. The global enable, the duty field, the bias bit and the frontplane mask are sampled only on the tick that starts a new frame. Every frame is therefore built from a single consistent configuration.

Top module: `lcd_mux_driver`

## Requirements
- R1: The display store has 32 words of 4 bits. The word address is the frontplane number and bit b is the segment on backplane b. A write happens on a clock edge with `bus_we` high. `bus_rdata` shows the word at `bus_addr` one clock later.
- R2: Mode decoding and fallback. With duty field d, d+1 backplanes are active. d=0 uses 2 levels (top code 1) and ignores the bias bit. d=1 uses 3 levels (top code 2) when the bias bit is 0 and 4 levels (top code 3) when it is 1. d=2 and d=3 always use 4 levels (top code 3).
- R3: Each tick toggles the phase. A tick in phase 1 moves to the next slot, wrapping from slot d to slot 0. Reset places the sequencer at slot 0, phase 0.
- R4: A backplane whose slot is current outputs the top code in phase 0 and code 0 in phase 1. Every other active backplane outputs code 1 in phase 0 and top-1 in phase 1. These codes do not depend on the store contents.
- R5: An enabled frontplane whose bit for the current slot is 1 (ON) outputs code 0 in phase 0 and the top code in phase 1.
- R6: An enabled frontplane whose bit is 0 (OFF) outputs top-1 in phase 0 and code 1 in phase 1. In the 2-level mode it instead copies the selected backplane: code 1, then code 0.
- R7: Frontplane f has its drive-enable high only when both the latched global enable and latched mask bit f are 1. Otherwise its enable is low and its code is 0. Setting a mask bit while the global enable is 0 produces no output.
- R8: Backplane b has its drive-enable high only when the driver is enabled and b ≤ d. Otherwise its enable is low and its code is 0.
- R9: The global enable, duty, bias and mask take effect only on the tick that returns the sequencer to slot 0, phase 0. A change made mid-frame does not alter the frame in progress.
- R10: Turning the driver on or off never changes the store. The store stays readable and writable while the driver runs, and a written word shows on the frontplane outputs at the next output update.
- R11: After reset, every drive-enable is low and every code is 0. The latched configuration is off with d=0 until the first frame boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle phase advance strobe from the prescaler |
| drv_en | input | 1 | Global driver enable (latched at frame boundary) |
| duty_sel | input | 2 | Duty field: active backplane count minus one |
| bias_sel | input | 1 | Bias select, used only when duty_sel is 1 |
| fp_mask | input | 32 | Per-frontplane enable mask |
| bus_addr | input | 5 | Store word address (frontplane number) |
| bus_we | input | 1 | Store write strobe |
| bus_wdata | input | 4 | Store write data |
| bus_rdata | output | 4 | Store read data, one cycle latency |
| fp_lvl | output | 64 | Level code per frontplane, 2 bits each, pin f at [2f+1:2f] |
| fp_oe | output | 32 | Drive-enable per frontplane |
| bp_lvl | output | 8 | Level code per backplane, 2 bits each, pin b at [2b+1:2b] |
| bp_oe | output | 4 | Drive-enable per backplane |

## Verification
The assertions assume that `tick` is a single-cycle pulse arriving no faster than every other clock. They also assume the configuration inputs are the only path to the latched mode. Several properties relate the registered outputs to the sequencer state of the previous cycle, so they also assume that state moves only on a tick. The stimulus issues each tick as an isolated one-cycle pulse followed by idle cycles. It changes mode, mask and enable between ticks, often mid-frame, and writes the store only between ticks. Every legal and illegal duty/bias code is swept across several whole frames against a bench model of the slot, phase and latched configuration.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

  localparam int BP_COUNT = 4;
  localparam int SLOT_W   = 2;
  localparam int LVL_W    = 2;

  typedef struct packed {
    logic              en;
    logic [SLOT_W-1:0] duty;
    logic              bias;
  } lcd_mode_t;

  // Highest level code for a duty/bias pair; illegal pairs fold onto legal ones.
  function automatic logic [LVL_W-1:0] top_code(input logic [SLOT_W-1:0] duty,
                                                input logic bias);
    case (duty)
      2'd0:    return 2'd1;
      2'd1:    return bias ? 2'd3 : 2'd2;
      default: return 2'd3;
    endcase
  endfunction

  function automatic logic [LVL_W-1:0] bp_code(input logic active, input logic ph,
                                               input logic [LVL_W-1:0] top);
    if (active) return ph ? 2'd0 : top;
    return ph ? (top - 2'd1) : 2'd1;
  endfunction

  function automatic logic [LVL_W-1:0] fp_code(input logic on, input logic ph,
                                               input logic [LVL_W-1:0] top);
    if (on) return ph ? top : 2'd0;
    if (top == 2'd1) return ph ? 2'd0 : 2'd1;
    return ph ? 2'd1 : (top - 2'd1);
  endfunction

endpackage

// File: rtl/lcd_seg_ram.sv
module lcd_seg_ram
  import lcd_seq_pkg::*;
#(
  parameter int NUM_FP = 32,
  parameter int AW     = $clog2(NUM_FP)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [AW-1:0]                bus_addr,
  input  logic                         bus_we,
  input  logic [BP_COUNT-1:0]          bus_wdata,
  output logic [BP_COUNT-1:0]          bus_rdata,
  output logic [NUM_FP*BP_COUNT-1:0]   seg_bits
);
  localparam logic [AW:0] FP_CNT = NUM_FP[AW:0];

  // Contents are deliberately left unreset.
  logic [BP_COUNT-1:0] mem [NUM_FP];
  logic                addr_ok;

  assign addr_ok = ({1'b0, bus_addr} < FP_CNT);

  always_ff @(posedge clk) begin
    if (bus_we && addr_ok) mem[bus_addr] <= bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)          bus_rdata <= '0;
    else if (addr_ok) bus_rdata <= mem[bus_addr];
    else              bus_rdata <= '0;
  end

  for (genvar w = 0; w < NUM_FP; w++) begin : g_word
    assign seg_bits[w*BP_COUNT +: BP_COUNT] = mem[w];

    // R10: a word only changes when the bus writes that word
    p_ram_hold_r10: assert property (@(posedge clk) disable iff (rst)
      !(bus_we && bus_addr == AW'(w)) |=> $stable(mem[w]));
  end

endmodule

// File: rtl/lcd_frame_timer.sv
module lcd_frame_timer
  import lcd_seq_pkg::*;
#(
  parameter int NUM_FP = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  lcd_mode_t         mode_in,
  input  logic [NUM_FP-1:0] fp_en_in,
  output logic [SLOT_W-1:0] slot,
  output logic              phase,
  output lcd_mode_t         act_mode,
  output logic [NUM_FP-1:0] act_fp_en
);
  logic wrap;
  assign wrap = phase && (slot == act_mode.duty);

  always_ff @(posedge clk) begin
    if (rst) begin
      slot      <= '0;
      phase     <= 1'b0;
      act_mode  <= '0;
      act_fp_en <= '0;
    end else if (tick) begin
      phase <= ~phase;
      if (phase) begin
        if (wrap) begin
          slot      <= '0;
          act_mode  <= mode_in;
          act_fp_en <= fp_en_in;
        end else begin
          slot <= slot + SLOT_W'(1);
        end
      end
    end
  end

  // R3: slot index stays inside the latched duty
  p_slot_range_r3: assert property (@(posedge clk) disable iff (rst)
    slot <= act_mode.duty);

  // R3: every tick flips the phase
  p_phase_flip_r3: assert property (@(posedge clk) disable iff (rst)
    tick |=> (phase != $past(phase)));

  // R9: the latched configuration only changes as a new frame opens
  p_cfg_at_boundary_r9: assert property (@(posedge clk) disable iff (rst)
    (act_mode != $past(act_mode) || act_fp_en != $past(act_fp_en))
      |-> (slot == '0 && !phase));

endmodule

// File: rtl/lcd_level_map.sv
module lcd_level_map
  import lcd_seq_pkg::*;
#(
  parameter int NUM_FP = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [SLOT_W-1:0]           slot,
  input  logic                        phase,
  input  lcd_mode_t                   act_mode,
  input  logic [NUM_FP-1:0]           act_fp_en,
  input  logic [NUM_FP*BP_COUNT-1:0]  seg_bits,
  output logic [NUM_FP*LVL_W-1:0]     fp_lvl,
  output logic [NUM_FP-1:0]           fp_oe,
  output logic [BP_COUNT*LVL_W-1:0]   bp_lvl,
  output logic [BP_COUNT-1:0]         bp_oe
);
  logic [LVL_W-1:0] top;
  assign top = top_code(act_mode.duty, act_mode.bias);

  always_ff @(posedge clk) begin
    if (rst) begin
      fp_lvl <= '0;
      fp_oe  <= '0;
    end else begin
      for (int f = 0; f < NUM_FP; f++) begin
        if (act_mode.en && act_fp_en[f]) begin
          fp_lvl[f*LVL_W +: LVL_W] <= fp_code(seg_bits[f*BP_COUNT + int'(slot)], phase, top);
          fp_oe[f]                 <= 1'b1;
        end else begin
          fp_lvl[f*LVL_W +: LVL_W] <= '0;
          fp_oe[f]                 <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bp_lvl <= '0;
      bp_oe  <= '0;
    end else begin
      for (int b = 0; b < BP_COUNT; b++) begin
        if (act_mode.en && (SLOT_W'(b) <= act_mode.duty)) begin
          bp_lvl[b*LVL_W +: LVL_W] <= bp_code(slot == SLOT_W'(b), phase, top);
          bp_oe[b]                 <= 1'b1;
        end else begin
          bp_lvl[b*LVL_W +: LVL_W] <= '0;
          bp_oe[b]                 <= 1'b0;
        end
      end
    end
  end

  for (genvar f = 0; f < NUM_FP; f++) begin : g_fp_chk
    // R7: a pin without both enables is released and parked at code 0
    p_fp_gate_r7: assert property (@(posedge clk) disable iff (rst)
      (!act_mode.en || !act_fp_en[f]) |=> (!fp_oe[f] && fp_lvl[f*LVL_W +: LVL_W] == '0));
    // R6: the two-level mode never produces a code above 1
    p_two_level_r6: assert property (@(posedge clk) disable iff (rst)
      (act_mode.duty == '0) |=> (fp_lvl[f*LVL_W +: LVL_W] <= 2'd1));
  end

  for (genvar b = 0; b < BP_COUNT; b++) begin : g_bp_chk
    // R8: unused or disabled backplanes are high impedance
    p_bp_hiz_r8: assert property (@(posedge clk) disable iff (rst)
      (!act_mode.en || act_mode.duty < SLOT_W'(b)) |=> !bp_oe[b]);
  end

endmodule

// File: rtl/lcd_mux_driver.sv
module lcd_mux_driver
  import lcd_seq_pkg::*;
#(
  parameter int NUM_FP = 32,
  parameter int AW     = $clog2(NUM_FP)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        tick,
  input  logic                        drv_en,
  input  logic [1:0]                  duty_sel,
  input  logic                        bias_sel,
  input  logic [NUM_FP-1:0]           fp_mask,
  input  logic [AW-1:0]               bus_addr,
  input  logic                        bus_we,
  input  logic [3:0]                  bus_wdata,
  output logic [3:0]                  bus_rdata,
  output logic [NUM_FP*2-1:0]         fp_lvl,
  output logic [NUM_FP-1:0]           fp_oe,
  output logic [7:0]                  bp_lvl,
  output logic [3:0]                  bp_oe
);
  lcd_mode_t                   mode_in;
  lcd_mode_t                   act_mode;
  logic [NUM_FP-1:0]           act_fp_en;
  logic [SLOT_W-1:0]           slot;
  logic                        phase;
  logic [NUM_FP*BP_COUNT-1:0]  seg_bits;

  assign mode_in.en   = drv_en;
  assign mode_in.duty = duty_sel;
  assign mode_in.bias = bias_sel;

  lcd_seg_ram #(.NUM_FP(NUM_FP), .AW(AW)) u_ram (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .seg_bits(seg_bits)
  );

  lcd_frame_timer #(.NUM_FP(NUM_FP)) u_timer (
    .clk(clk), .rst(rst), .tick(tick), .mode_in(mode_in), .fp_en_in(fp_mask),
    .slot(slot), .phase(phase), .act_mode(act_mode), .act_fp_en(act_fp_en)
  );

  lcd_level_map #(.NUM_FP(NUM_FP)) u_map (
    .clk(clk), .rst(rst), .slot(slot), .phase(phase), .act_mode(act_mode),
    .act_fp_en(act_fp_en), .seg_bits(seg_bits), .fp_lvl(fp_lvl), .fp_oe(fp_oe),
    .bp_lvl(bp_lvl), .bp_oe(bp_oe)
  );

  // R11: out of reset every pin is released
  p_reset_off_r11: assert property (@(posedge clk)
    $fell(rst) |-> (fp_oe == '0 && bp_oe == '0));

endmodule

// File: tb/lcd_mux_driver_test.sv
module lcd_mux_driver_test;
  localparam int NFP = 32;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           tick = 1'b0;
  logic           drv_en = 1'b0;
  logic [1:0]     duty_sel = 2'd0;
  logic           bias_sel = 1'b0;
  logic [NFP-1:0] fp_mask = '0;
  logic [4:0]     bus_addr = '0;
  logic           bus_we = 1'b0;
  logic [3:0]     bus_wdata = '0;
  logic [3:0]     bus_rdata;
  logic [NFP*2-1:0] fp_lvl;
  logic [NFP-1:0] fp_oe;
  logic [7:0]     bp_lvl;
  logic [3:0]     bp_oe;

  lcd_mux_driver uut (
    .clk(clk), .rst(rst), .tick(tick), .drv_en(drv_en), .duty_sel(duty_sel),
    .bias_sel(bias_sel), .fp_mask(fp_mask), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fp_lvl(fp_lvl), .fp_oe(fp_oe),
    .bp_lvl(bp_lvl), .bp_oe(bp_oe)
  );

  always #10 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // Bench model of sequencer and store
  logic [3:0]     shadow [NFP];
  int             m_slot = 0, m_phase = 0, m_duty = 0;
  bit             m_en = 0, m_bias = 0;
  logic [NFP-1:0] m_mask = '0;

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input int a, input logic [3:0] d);
    @(negedge clk);
    bus_addr = 5'(a); bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    shadow[a] = d;
  endtask

  task automatic bus_read_check(input string req, input int a);
    @(negedge clk);
    bus_addr = 5'(a);
    @(negedge clk);
    check(req, 128'(bus_rdata), 128'(shadow[a]));
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    if (m_phase == 0) m_phase = 1;
    else begin
      m_phase = 0;
      if (m_slot == m_duty) begin
        m_slot = 0; m_en = drv_en; m_duty = int'(duty_sel);
        m_bias = bias_sel; m_mask = fp_mask;
      end else m_slot++;
    end
    @(negedge clk);
  endtask

  task automatic check_pins(input string req);
    int levels, top;
    logic [NFP*2-1:0] e_fl; logic [NFP-1:0] e_fo;
    logic [7:0] e_bl; logic [3:0] e_bo;
    levels = (m_duty == 0) ? 2 : (m_duty == 1 ? (m_bias ? 4 : 3) : 4);
    top = levels - 1;
    e_fl = '0; e_fo = '0; e_bl = '0; e_bo = '0;
    for (int b = 0; b < 4; b++) begin
      if (m_en && b <= m_duty) begin
        e_bo[b] = 1'b1;
        if (b == m_slot) e_bl[b*2 +: 2] = 2'(m_phase ? 0 : top);
        else             e_bl[b*2 +: 2] = 2'(m_phase ? top - 1 : 1);
      end
    end
    for (int f = 0; f < NFP; f++) begin
      if (m_en && m_mask[f]) begin
        e_fo[f] = 1'b1;
        if (shadow[f][m_slot])  e_fl[f*2 +: 2] = 2'(m_phase ? top : 0);
        else if (levels == 2)   e_fl[f*2 +: 2] = 2'(m_phase ? 0 : 1);
        else                    e_fl[f*2 +: 2] = 2'(m_phase ? 1 : top - 1);
      end
    end
    check({req, " bp"}, {120'd0, bp_lvl}, {120'd0, e_bl});
    check({req, " bp_oe"}, 128'(bp_oe), 128'(e_bo));
    check({req, " fp"}, 128'(fp_lvl), 128'(e_fl));
    check({req, " fp_oe"}, 128'(fp_oe), 128'(e_fo));
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NFP; i++) shadow[i] = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: reset state
    check("R11 reset", {fp_oe, fp_lvl[31:0], bp_oe, bp_lvl}, '0);

    // R1: fill the store and read it back
    for (int i = 0; i < NFP; i++) bus_write(i, 4'((i * 7 + 5) % 16));
    for (int i = 0; i < NFP; i++) bus_read_check("R1 readback", i);

    // R9: new settings before any boundary produce nothing
    drv_en = 1'b1; duty_sel = 2'd3; bias_sel = 1'b1; fp_mask = '1;
    repeat (3) @(negedge clk);
    check("R9 no early start", 128'({fp_oe, bp_oe}), '0);

    // R2 R3 R4 R5 R6 R8: sweep every duty/bias code across whole frames
    for (int m = 0; m < 8; m++) begin
      duty_sel = 2'(m >> 1); bias_sel = m[0];
      for (int t = 0; t < 24; t++) begin
        do_tick();
        check_pins("R2/R3/R4/R5/R6/R8 sweep");
      end
    end

    // R9: mid-frame change of duty keeps the running frame
    duty_sel = 2'd3; bias_sel = 1'b1;
    for (int t = 0; t < 16; t++) do_tick();
    do_tick(); do_tick();
    duty_sel = 2'd0;
    do_tick();
    check("R9 mid-frame hold", 128'(bp_oe), 128'(4'hF));
    for (int t = 0; t < 12; t++) begin do_tick(); check_pins("R9 change"); end

    // R7: per-pin mask
    fp_mask = 32'hA5C3_0F81; duty_sel = 2'd2; bias_sel = 1'b0;
    for (int t = 0; t < 18; t++) begin do_tick(); check_pins("R7 mask"); end

    // R7 R8: global enable off with mask set
    drv_en = 1'b0; fp_mask = '1;
    for (int t = 0; t < 16; t++) begin do_tick(); check_pins("R7/R8 disabled"); end
    check("R7 all off", 128'({fp_oe, bp_oe}), '0);

    // R10: store untouched by enable toggle, usable while disabled
    for (int i = 0; i < NFP; i += 3) bus_read_check("R10 after disable", i);
    bus_write(9, 4'h6);
    bus_read_check("R10 write while off", 9);

    // R10: live update while enabled
    drv_en = 1'b1; duty_sel = 2'd3; bias_sel = 1'b1;
    for (int t = 0; t < 10; t++) do_tick();
    bus_write(3, ~shadow[3]);
    bus_write(17, ~shadow[17]);
    @(negedge clk);
    check_pins("R10 live write");
    for (int t = 0; t < 16; t++) begin do_tick(); check_pins("R10 running"); end
    for (int i = 0; i < NFP; i += 4) bus_read_check("R10 final", i);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

endmodule